// File: doc/BRIEF.md
# Exception State Register Set

This block keeps the exception-related state of a small in-order RISC core: the faulting data address, the mode/enable status word, the cause word and the exception return address. The core's control sequencer raises a one-cycle exception request with a four-bit reason code. In that same cycle the block records the reason and the address of the offending instruction. When the reason is an address error, it also records the faulting memory address. It then pushes a three-deep stack of kernel/enable pairs, so that the handler runs in kernel mode with interrupts off. A return-from-exception strobe pops that stack.

Hardware interrupt lines are latched into sticky pending bits. Each pending bit is gated by its own mask bit and by the current enable bit, and the result forms a single "take an interrupt" flag for the sequencer. The block also drives the fixed handler entry address. Software reads each register by its number with a move-from port. It writes the status word, and acknowledges pending interrupts, with a move-to port.

Top module: `exc_state_regs`

## Requirements
- R1: After reset, every register reads zero and `irq_take_o` is 0.
- R2: Reads are combinational on `mf_num_i`: 8 returns the bad address, 12 the status word, 13 the cause word and 14 the return address. Any other number reads zero. Status bits 31:16 and 7:6 read zero. Cause bits 31:16, 9:6 and 1:0 read zero.
- R3: On an exception request, status bits 5:0 become the old bits 3:0 shifted up by two, with bits 1:0 cleared. The current pair sits in bits 1:0, with enable in bit 0 and user mode in bit 1.
- R4: On a return strobe without an exception, status bits 3:0 take the old bits 5:2, and bits 5:4 keep their value.
- R5: Status bits 5:0 follow this priority: exception first, then return, then a move-to of register 12.
- R6: A move-to of number 12 loads status bits 15:8 (mask) and 5:0 from the data. Data bits 31:16 and 7:6 are dropped.
- R7: On an exception, cause bits 5:2 take `exc_code_i`.
- R8: A high level on hardware line i sets cause bit 10+i from the next cycle on. The bit stays set until a move-to of number 13 writes 1 to bit 10+i. If the line is high in that same cycle, the bit stays set.
- R9: On an exception, the return address register takes `exc_pc_i` minus 4.
- R10: The bad address register takes `exc_badaddr_i` only on an exception with code 4 or 5. Any other code leaves it unchanged.
- R11: `handler_pc_o` is always 0x80000080.
- R12: `irq_take_o` is 1 exactly when status bit 0 is 1 and some cause bit 10+i and status bit 10+i are both 1.
- R13: A move-to of any number other than 12 or 13 changes no register. A move-to of 13 changes nothing but pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | One-cycle exception request |
| exc_code_i | input | 4 | Reason code of the exception |
| exc_pc_i | input | 32 | PC value at the exception (offending instruction + 4) |
| exc_badaddr_i | input | 32 | Faulting memory address |
| hw_irq_i | input | 6 | Hardware interrupt lines |
| rfe_i | input | 1 | Return-from-exception strobe |
| mt_en_i | input | 1 | Move-to write enable |
| mt_num_i | input | 5 | Move-to register number |
| mt_data_i | input | 32 | Move-to data |
| mf_num_i | input | 5 | Move-from register number |
| mf_data_o | output | 32 | Move-from data |
| handler_pc_o | output | 32 | Handler entry address |
| irq_take_o | output | 1 | An enabled, unmasked interrupt is pending |

## Verification
Every register is updated at the edge where its event arrives. A wrong internal state therefore shows up on the next read, one cycle after the stimulus. A wrong stack shift shows up in status bits 5:0. It also shows up through `irq_take_o`, which depends on the current enable bit. A pending bit that is lost or stuck appears both in cause bits 15:10 and as a missing or extra interrupt-take flag. The reference model reads all four registers and two unused numbers after every clock. A divergence is therefore caught in the first cycle it appears, not when some later path happens to expose it.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN      = 32;
  localparam int NUM_W     = 5;
  localparam int CODE_W    = 4;
  localparam int MASK_W    = 8;
  localparam int STK_W     = 6;
  localparam int MASK_LSB  = 8;
  localparam int CODE_LSB  = 2;
  localparam int PEND_LSB  = 10;

  localparam logic [NUM_W-1:0] RN_BADVA  = 5'd8;
  localparam logic [NUM_W-1:0] RN_STATUS = 5'd12;
  localparam logic [NUM_W-1:0] RN_CAUSE  = 5'd13;
  localparam logic [NUM_W-1:0] RN_EPC    = 5'd14;

  typedef enum logic [CODE_W-1:0] {
    EC_INT     = 4'd0,
    EC_ADDR_LD = 4'd4,
    EC_ADDR_ST = 4'd5,
    EC_BUS_I   = 4'd6,
    EC_BUS_D   = 4'd7,
    EC_SYSCALL = 4'd8,
    EC_BREAK   = 4'd9,
    EC_RSVD    = 4'd10,
    EC_OVF     = 4'd12
  } exc_code_e;
endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack #(
  parameter int STK_W  = 6,
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_i,
  input  logic              rfe_i,
  input  logic              wr_i,
  input  logic [MASK_W-1:0] wr_mask_i,
  input  logic [STK_W-1:0]  wr_stk_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [STK_W-1:0]  stk_o
);
  localparam int PAIR = 2;

  logic [STK_W-1:0]  stk_q, stk_n;
  logic [MASK_W-1:0] mask_q, mask_n;
  logic              stk_en, mask_en;

  always_comb begin
    stk_n = stk_q;
    if (exc_i)
      stk_n = {stk_q[STK_W-PAIR-1:0], {PAIR{1'b0}}};
    else if (rfe_i)
      stk_n = {stk_q[STK_W-1:STK_W-PAIR], stk_q[STK_W-1:PAIR]};
    else if (wr_i)
      stk_n = wr_stk_i;
    stk_en  = exc_i | rfe_i | wr_i;
    mask_n  = wr_mask_i;
    mask_en = wr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q  <= '0;
      mask_q <= '0;
    end else begin
      if (stk_en)  stk_q  <= stk_n;
      if (mask_en) mask_q <= mask_n;
    end
  end

  assign stk_o  = stk_q;
  assign mask_o = mask_q;

  // R3
  exc_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> (stk_o[PAIR-1:0] == '0) &&
              (stk_o[STK_W-1:PAIR] == $past(stk_o[STK_W-PAIR-1:0])));

  // R4
  rfe_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_i && !exc_i) |=> (stk_o[STK_W-PAIR-1:0] == $past(stk_o[STK_W-1:PAIR])) &&
                          (stk_o[STK_W-1:STK_W-PAIR] == $past(stk_o[STK_W-1:STK_W-PAIR])));
endmodule

// File: rtl/exc_cause_unit.sv
module exc_cause_unit #(
  parameter int NUM_HW = 6,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [NUM_HW-1:0] hw_irq_i,
  input  logic              clr_i,
  input  logic [NUM_HW-1:0] clr_bits_i,
  input  logic [NUM_HW-1:0] irq_mask_i,
  input  logic              ie_i,
  output logic [CODE_W-1:0] code_o,
  output logic [NUM_HW-1:0] pend_o,
  output logic              take_o
);
  logic [CODE_W-1:0] code_q;
  logic [NUM_HW-1:0] pend_q, pend_n, clr_vec;
  logic              pend_en;

  always_comb begin
    clr_vec = clr_i ? clr_bits_i : '0;
    pend_n  = (pend_q & ~clr_vec) | hw_irq_i;
    pend_en = clr_i | (|hw_irq_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      pend_q <= '0;
    end else begin
      if (exc_i)   code_q <= code_i;
      if (pend_en) pend_q <= pend_n;
    end
  end

  assign code_o = code_q;
  assign pend_o = pend_q;
  assign take_o = ie_i & (|(pend_q & irq_mask_i));

  // R7
  code_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> code_o == $past(code_i));

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_irq_i) |=> ((pend_o & $past(hw_irq_i)) == $past(hw_irq_i)));

  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/exc_addr_capture.sv
module exc_addr_capture #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   badaddr_i,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   badva_o
);
  import exc_pkg::*;

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [XLEN-1:0] epc_q, epc_n, bad_q;
  logic            addr_fault;

  always_comb begin
    epc_n      = pc_i - INSN_BYTES;
    addr_fault = exc_i && ((code_i == CODE_W'(EC_ADDR_LD)) ||
                           (code_i == CODE_W'(EC_ADDR_ST)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q <= '0;
      bad_q <= '0;
    end else begin
      if (exc_i)      epc_q <= epc_n;
      if (addr_fault) bad_q <= badaddr_i;
    end
  end

  assign epc_o   = epc_q;
  assign badva_o = bad_q;

  // R9
  epc_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> epc_o == $past(pc_i) - INSN_BYTES);

  // R10
  badva_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_i && code_i != CODE_W'(EC_ADDR_LD) && code_i != CODE_W'(EC_ADDR_ST))
      |=> $stable(badva_o));
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
  parameter int              NUM_HW_IRQ   = 6,
  parameter logic [31:0]     HANDLER_ADDR = 32'h8000_0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_req_i,
  input  logic [3:0]  exc_code_i,
  input  logic [31:0] exc_pc_i,
  input  logic [31:0] exc_badaddr_i,
  input  logic [5:0]  hw_irq_i,
  input  logic        rfe_i,
  input  logic        mt_en_i,
  input  logic [4:0]  mt_num_i,
  input  logic [31:0] mt_data_i,
  input  logic [4:0]  mf_num_i,
  output logic [31:0] mf_data_o,
  output logic [31:0] handler_pc_o,
  output logic        irq_take_o
);
  import exc_pkg::*;

  localparam int MASK_OFS = PEND_LSB - MASK_LSB;

  logic                  rst_meta, rst_sync;
  logic [MASK_W-1:0]     mask;
  logic [STK_W-1:0]      stk;
  logic [CODE_W-1:0]     code;
  logic [NUM_HW_IRQ-1:0] pend;
  logic [XLEN-1:0]       epc, badva;
  logic                  wr_status, wr_cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    wr_status = mt_en_i && (mt_num_i == RN_STATUS);
    wr_cause  = mt_en_i && (mt_num_i == RN_CAUSE);
  end

  exc_mode_stack #(.STK_W(STK_W), .MASK_W(MASK_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_sync),
    .exc_i     (exc_req_i),
    .rfe_i     (rfe_i),
    .wr_i      (wr_status),
    .wr_mask_i (mt_data_i[MASK_LSB +: MASK_W]),
    .wr_stk_i  (mt_data_i[STK_W-1:0]),
    .mask_o    (mask),
    .stk_o     (stk)
  );

  exc_cause_unit #(.NUM_HW(NUM_HW_IRQ), .CODE_W(CODE_W)) u_cause (
    .clk        (clk),
    .rst_n      (rst_sync),
    .exc_i      (exc_req_i),
    .code_i     (exc_code_i),
    .hw_irq_i   (hw_irq_i[NUM_HW_IRQ-1:0]),
    .clr_i      (wr_cause),
    .clr_bits_i (mt_data_i[PEND_LSB +: NUM_HW_IRQ]),
    .irq_mask_i (mask[MASK_OFS +: NUM_HW_IRQ]),
    .ie_i       (stk[0]),
    .code_o     (code),
    .pend_o     (pend),
    .take_o     (irq_take_o)
  );

  exc_addr_capture #(.XLEN(XLEN), .CODE_W(CODE_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_sync),
    .exc_i     (exc_req_i),
    .code_i    (exc_code_i),
    .pc_i      (exc_pc_i),
    .badaddr_i (exc_badaddr_i),
    .epc_o     (epc),
    .badva_o   (badva)
  );

  always_comb begin
    mf_data_o = '0;
    unique case (mf_num_i)
      RN_BADVA:  mf_data_o = badva;
      RN_EPC:    mf_data_o = epc;
      RN_STATUS: begin
        mf_data_o[MASK_LSB +: MASK_W] = mask;
        mf_data_o[STK_W-1:0]          = stk;
      end
      RN_CAUSE: begin
        mf_data_o[PEND_LSB +: NUM_HW_IRQ] = pend;
        mf_data_o[CODE_LSB +: CODE_W]     = code;
      end
      default: mf_data_o = '0;
    endcase
  end

  assign handler_pc_o = HANDLER_ADDR;

  // R12
  take_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    irq_take_o |-> stk[0]);

  // R13
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (mt_en_i && !wr_status && !wr_cause && !exc_req_i && !rfe_i)
      |=> $stable(stk) && $stable(mask) && $stable(epc) && $stable(badva));
endmodule

// File: tb/exc_state_regs_bench.sv
`timescale 1ns/1ps
module exc_state_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req;
  logic [3:0]  exc_code;
  logic [31:0] exc_pc, exc_bad;
  logic [5:0]  hw_irq;
  logic        rfe;
  logic        mt_en;
  logic [4:0]  mt_num;
  logic [31:0] mt_data;
  logic [4:0]  mf_num;
  logic [31:0] mf_data, handler_pc;
  logic        irq_take;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_stk, m_mask, m_code, m_pend;
  logic [31:0] m_epc, m_bad;

  always #2.5 clk = ~clk;

  exc_state_regs u_exc_state_regs (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_code_i(exc_code),
    .exc_pc_i(exc_pc), .exc_badaddr_i(exc_bad), .hw_irq_i(hw_irq), .rfe_i(rfe),
    .mt_en_i(mt_en), .mt_num_i(mt_num), .mt_data_i(mt_data), .mf_num_i(mf_num),
    .mf_data_o(mf_data), .handler_pc_o(handler_pc), .irq_take_o(irq_take)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int num);
    case (num)
      8:  return m_bad;
      12: return 32'((m_mask << 8) | m_stk);
      13: return 32'((m_pend << 10) | (m_code << 2));
      14: return m_epc;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_tick();
    bit wr_st = mt_en && mt_num == 5'd12;
    bit wr_ca = mt_en && mt_num == 5'd13;
    if (exc_req)  m_stk = (m_stk * 4) % 64;
    else if (rfe) m_stk = (m_stk / 4) | (m_stk & 'h30);
    else if (wr_st) m_stk = int'(mt_data[5:0]);
    if (wr_st) m_mask = int'(mt_data[15:8]);
    if (exc_req) begin
      m_code = int'(exc_code);
      m_epc  = exc_pc - 32'd4;
      if (exc_code == 4'd4 || exc_code == 4'd5) m_bad = exc_bad;
    end
    if (wr_ca) m_pend = m_pend & ~int'(mt_data[15:10]);
    m_pend = m_pend | int'(hw_irq);
  endtask

  task automatic compare(string req);
    int nums[6] = '{8, 12, 13, 14, 3, 31};
    foreach (nums[k]) begin
      mf_num = 5'(nums[k]);
      #0.2;
      check((nums[k] == 3 || nums[k] == 31) ? "R2" : req,
            $sformatf("read %0d", nums[k]), mf_data, exp_read(nums[k]));
    end
    check("R11", "handler_pc", handler_pc, 32'h8000_0080);
    check("R12", "irq_take", {31'b0, irq_take},
          {31'b0, ((m_stk & 1) != 0) && ((m_pend & (m_mask >> 2)) != 0)});
  endtask

  task automatic idle_inputs();
    exc_req = 0; exc_code = 0; exc_pc = 0; exc_bad = 0; hw_irq = 0;
    rfe = 0; mt_en = 0; mt_num = 0; mt_data = 0;
  endtask

  task automatic step(string req);
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare(req);
    idle_inputs();
  endtask

  task automatic do_exc(logic [3:0] c, logic [31:0] pc, logic [31:0] ba, string req);
    exc_req = 1; exc_code = c; exc_pc = pc; exc_bad = ba; step(req);
  endtask

  task automatic do_mt(logic [4:0] n, logic [31:0] d, string req);
    mt_en = 1; mt_num = n; mt_data = d; step(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_inputs();
    mf_num = 0;
    m_stk = 0; m_mask = 0; m_code = 0; m_pend = 0; m_epc = 0; m_bad = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) step("R1");

    // R6: full write, bits 31:16 and 7:6 dropped
    do_mt(5'd12, 32'hFFFF_FFFF, "R6");
    do_mt(5'd12, 32'h0000_A5C9, "R6");
    // R3 / R7 / R9: overflow exception
    do_mt(5'd12, 32'h0000_0007, "R6");
    do_exc(4'd12, 32'h0000_0404, 32'hDEAD_0000, "R3");
    do_exc(4'd10, 32'h0000_1000, 32'h1234_5678, "R7");
    // R4: two returns
    rfe = 1; step("R4");
    rfe = 1; step("R4");
    // R10: address faults capture, others keep
    do_exc(4'd4, 32'h0000_2008, 32'hCAFE_0001, "R10");
    do_exc(4'd8, 32'h0000_3000, 32'hBBBB_BBBB, "R10");
    do_exc(4'd5, 32'h0000_4000, 32'hCAFE_0002, "R10");
    do_exc(4'd0, 32'h0000_0000, 32'h9999_9999, "R9");
    // R5: priority exc > rfe > write
    do_mt(5'd12, 32'h0000_FF2D, "R6");
    exc_req = 1; exc_code = 4'd9; exc_pc = 32'h100; rfe = 1; step("R5");
    rfe = 1; mt_en = 1; mt_num = 5'd12; mt_data = 32'h0000_FF3F; step("R5");
    exc_req = 1; exc_code = 4'd6; mt_en = 1; mt_num = 5'd12; mt_data = 32'h0000_0015; step("R5");
    // R8 / R12: pending set, mask, enable, clear
    do_mt(5'd12, 32'h0000_0001, "R12");
    hw_irq = 6'b000100; step("R8");
    step("R8");
    do_mt(5'd12, 32'h0000_1000, "R12");
    do_mt(5'd12, 32'h0000_1001, "R12");
    hw_irq = 6'b100001; step("R8");
    do_mt(5'd13, 32'h0000_0400, "R8");
    hw_irq = 6'b000100; mt_en = 1; mt_num = 5'd13; mt_data = 32'h0000_FC00; step("R8");
    do_mt(5'd13, 32'hFFFF_FFFF, "R8");
    // R13: stray writes
    do_mt(5'd8,  32'h1111_1111, "R13");
    do_mt(5'd14, 32'h2222_2222, "R13");
    do_mt(5'd3,  32'h3333_3333, "R13");
    do_mt(5'd13, 32'h0000_03FF, "R13");
    // mixed random traffic
    for (int i = 0; i < 300; i++) begin
      exc_req  = ($urandom % 6) == 0;
      exc_code = 4'($urandom);
      exc_pc   = $urandom & 32'hFFFF_FFFC;
      exc_bad  = $urandom;
      hw_irq   = (($urandom % 4) == 0) ? 6'($urandom) : 6'b0;
      rfe      = ($urandom % 5) == 0;
      mt_en    = ($urandom % 3) == 0;
      mt_num   = (($urandom % 2) == 0) ? 5'(12 + ($urandom % 3)) : 5'($urandom);
      mt_data  = $urandom;
      step("R5");
    end
    finish_run();
  end
endmodule